// File: doc/BRIEF.md
# System Low-Power Level Sequencer

This block is an application-side state machine that moves a design through its power levels. In full operation everything runs. In a reduced level the inputs of the external-memory interface are switched off through a bank-disable line for referenced I/O. From there the block can enter standby. It raises a standby request toward a standby controller and waits until that controller reports stop, standby and its standby flag together. It then sits in standby until an external wakeup arrives. On wakeup it drops the request, waits until the standby command has gone low, and sends a one-cycle flag-clear pulse as a handshake before it returns to full operation.

The block also gates a high-fanout clock. While the standby command coming back from the controller is high, the gated clock is held low. The block carries no data stream, so it has no valid/ready interface. All pins are plain level controls. The requests (`mem_off_req_i`, `sleep_req_i`) are levels sampled on every clock. They are not handshaked, and there is no back-pressure.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `level_o` is 0 (full operation) and `stby_req_o`, `flag_clr_o` and `bank_off_o` are low.
- R2: From full operation, `mem_off_req_i` high moves `level_o` to 1 (memory off) one clock later with `bank_off_o` high. Dropping the request in level 1 returns `level_o` to 0 one clock later with `bank_off_o` low.
- R3: `sleep_req_i` high in level 0 or 1 always passes through level 1. The next clock after level 1 enters level 2 (prepare), which raises `stby_req_o` while `bank_off_o` stays high.
- R4: In level 2, `stby_req_o` stays high and the level stays 2 until `stop_i`, `stdby_i` and `sflag_i` are all seen high at one clock edge. The level then becomes 3 (standby).
- R5: In level 3, `stby_req_o` and `bank_off_o` stay high and `flag_clr_o` stays low. `sleep_req_i` and `mem_off_req_i` have no effect there. `wake_i` passes two synchronizer flops, so the level becomes 4 (wakeup, `stby_req_o` low) on the third clock edge after `wake_i` rises. `wake_i` has no effect in level 0.
- R6: In level 4, the block waits for `stdby_i` low. The next clock gives level 5, in which `flag_clr_o` is high for exactly one cycle. The pulse never appears unless `stdby_i` was low at the edge before it.
- R7: `gclk_o` follows `fan_clk_i` while `stdby_i` is low and is held low while `stdby_i` is high.
- R8: After level 5 the block returns to level 0 with `bank_off_o` low. The next clock then honours a pending `mem_off_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_off_req_i | input | 1 | Request for the memory-off level |
| sleep_req_i | input | 1 | Request to enter standby |
| wake_i | input | 1 | Asynchronous wakeup, synchronized internally |
| stop_i | input | 1 | Stop indication from the standby controller |
| stdby_i | input | 1 | Standby command from the standby controller |
| sflag_i | input | 1 | Standby flag from the standby controller |
| fan_clk_i | input | 1 | High-fanout clock to be gated |
| stby_req_o | output | 1 | Standby request to the controller |
| flag_clr_o | output | 1 | One-cycle standby-flag clear pulse |
| bank_off_o | output | 1 | Disable for the referenced I/O bank |
| gclk_o | output | 1 | Gated high-fanout clock |
| level_o | output | 3 | Current level: 0 full, 1 memory off, 2 prepare, 3 standby, 4 wakeup, 5 flag clear |

## Verification
A wrong state register shows on `level_o` and on the decoded control outputs in the same cycle, because the outputs are registered next to the state. A skipped memory-off step shows as a level-2 entry that does not follow level 1. A wakeup that arrives too early or too late shows as `stby_req_o` falling on the wrong edge, off by the synchronizer depth. A premature flag-clear shows as a pulse while `stdby_i` is still high, or as a pulse more than one cycle wide, within two cycles of the wakeup level.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    LVL_FULL   = 3'd0,
    LVL_MEMOFF = 3'd1,
    LVL_PREP   = 3'd2,
    LVL_STBY   = 3'd3,
    LVL_WAKE   = 3'd4,
    LVL_CLEAR  = 3'd5
  } pwr_lvl_e;

  typedef struct packed {
    logic stby_req;
    logic bank_off;
    logic flag_clr;
  } pwr_ctl_t;

  // control levels that belong to each power level
  function automatic pwr_ctl_t lvl_decode(pwr_lvl_e l);
    pwr_ctl_t c;
    c.stby_req = (l == LVL_PREP) || (l == LVL_STBY);
    c.bank_off = (l == LVL_MEMOFF) || (l == LVL_PREP) ||
                 (l == LVL_STBY) || (l == LVL_WAKE);
    c.flag_clr = (l == LVL_CLEAR);
    return c;
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/pwr_level_fsm.sv
module pwr_level_fsm
  import pwr_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mem_off_req,
  input  logic     sleep_req,
  input  logic     wake_s,
  input  logic     stop_s,
  input  logic     stdby_s,
  input  logic     sflag_s,
  output pwr_lvl_e lvl,
  output pwr_ctl_t ctl
);
  pwr_lvl_e lvl_q, lvl_d;
  pwr_ctl_t ctl_q;

  logic ack_all;
  assign ack_all = stop_s && stdby_s && sflag_s;

  always_comb begin
    lvl_d = lvl_q;
    unique case (lvl_q)
      LVL_FULL:   if (sleep_req || mem_off_req) lvl_d = LVL_MEMOFF;
      LVL_MEMOFF: begin
        if (sleep_req)         lvl_d = LVL_PREP;
        else if (!mem_off_req) lvl_d = LVL_FULL;
      end
      LVL_PREP:   if (ack_all)  lvl_d = LVL_STBY;
      LVL_STBY:   if (wake_s)   lvl_d = LVL_WAKE;
      LVL_WAKE:   if (!stdby_s) lvl_d = LVL_CLEAR;
      LVL_CLEAR:  lvl_d = LVL_FULL;
      default:    lvl_d = LVL_FULL;
    endcase
  end

  // outputs registered alongside the state so they never glitch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LVL_FULL;
      ctl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      ctl_q <= lvl_decode(lvl_d);
    end
  end

  assign lvl = lvl_q;
  assign ctl = ctl_q;
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate (
  input  logic clk_i,
  input  logic block_i,
  output logic clk_o
);
  assign clk_o = clk_i & ~block_i;
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_off_req_i,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  input  logic       stop_i,
  input  logic       stdby_i,
  input  logic       sflag_i,
  input  logic       fan_clk_i,
  output logic       stby_req_o,
  output logic       flag_clr_o,
  output logic       bank_off_o,
  output logic       gclk_o,
  output logic [2:0] level_o
);
  logic     wake_s;
  pwr_lvl_e lvl;
  pwr_ctl_t ctl;

  pwr_wake_sync #(.STAGES(WAKE_STAGES)) u_wake_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (wake_i),
    .sync_o  (wake_s)
  );

  pwr_level_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_off_req (mem_off_req_i),
    .sleep_req   (sleep_req_i),
    .wake_s      (wake_s),
    .stop_s      (stop_i),
    .stdby_s     (stdby_i),
    .sflag_s     (sflag_i),
    .lvl         (lvl),
    .ctl         (ctl)
  );

  pwr_clk_gate u_gate (
    .clk_i   (fan_clk_i),
    .block_i (stdby_i),
    .clk_o   (gclk_o)
  );

  assign stby_req_o = ctl.stby_req;
  assign bank_off_o = ctl.bank_off;
  assign flag_clr_o = ctl.flag_clr;
  assign level_o    = lvl;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stdby_i,
  input logic       stop_i,
  input logic       sflag_i,
  input logic       stby_req_o,
  input logic       flag_clr_o,
  input logic       bank_off_o,
  input logic       gclk_o,
  input logic [2:0] level_o
);
  a_r1_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 3'd0) |-> (!stby_req_o && !flag_clr_o && !bank_off_o));

  a_r3_prep_after_memoff: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 3'd2 && $past(level_o) != 3'd2) |-> ($past(level_o) == 3'd1));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 3'd2 && !(stop_i && stdby_i && sflag_i)) |=> (stby_req_o && level_o == 3'd2));

  a_r5_standby_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 3'd3 && $past(level_o) == 3'd3) |-> (stby_req_o && bank_off_o && !flag_clr_o));

  a_r6_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_o |=> !flag_clr_o);

  a_r6_clr_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_o |-> !$past(stdby_i));

  a_r7_gate_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    stdby_i |-> !gclk_o);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stdby_i    (stdby_i),
  .stop_i     (stop_i),
  .sflag_i    (sflag_i),
  .stby_req_o (stby_req_o),
  .flag_clr_o (flag_clr_o),
  .bank_off_o (bank_off_o),
  .gclk_o     (gclk_o),
  .level_o    (level_o)
);

// File: tb/pwr_seq_top_bench.sv
`timescale 1ns/1ps
module pwr_seq_top_bench;
  logic clk = 1'b0;
  logic fan_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_off_req = 1'b0, sleep_req = 1'b0, wake = 1'b0;
  logic stop_m = 1'b0, stdby_m = 1'b0, sflag_m = 1'b0;
  logic stby_req, flag_clr, bank_off, gclk;
  logic [2:0] level;
  logic ack_en = 1'b0;
  int   dly_cnt = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  bit   prev_clr = 1'b0;
  string exp_q[$];

  localparam int ACK_DLY = 3;

  always #5 clk = ~clk;
  always #7 fan_clk = ~fan_clk;

  pwr_seq_top u_pwr_seq_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_off_req_i (mem_off_req),
    .sleep_req_i   (sleep_req),
    .wake_i        (wake),
    .stop_i        (stop_m),
    .stdby_i       (stdby_m),
    .sflag_i       (sflag_m),
    .fan_clk_i     (fan_clk),
    .stby_req_o    (stby_req),
    .flag_clr_o    (flag_clr),
    .bank_off_o    (bank_off),
    .gclk_o        (gclk),
    .level_o       (level)
  );

  // behavioural standby controller
  always_ff @(posedge clk) begin
    stop_m <= stby_req;
    if (!stby_req) begin
      stdby_m <= 1'b0;
      dly_cnt <= 0;
    end else if (ack_en) begin
      if (dly_cnt == ACK_DLY) stdby_m <= 1'b1;
      else dly_cnt <= dly_cnt + 1;
    end
    if (flag_clr)     sflag_m <= 1'b0;
    else if (stdby_m) sflag_m <= 1'b1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor for flag-clear pulses
  always @(negedge clk) begin
    if (rst_n && flag_clr) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected clear pulse actual=1 expected=0");
      end else begin
        void'(exp_q.pop_front());
      end
      chk("R6 stdby low at clear", stdby_m, 0);
      chk("R6 pulse width", int'(prev_clr), 0);
    end
    prev_clr = flag_clr;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hang expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1 level in reset", level, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 level", level, 0);
    chk("R1 req", stby_req, 0);
    chk("R1 clr", flag_clr, 0);
    chk("R1 bank", bank_off, 0);

    // R5: wake has no effect in full operation
    wake = 1'b1; cyc(4); wake = 1'b0; cyc(3);
    chk("R5 wake ignored in level 0", level, 0);

    // R7: clock passes while stdby low
    for (int i = 0; i < 5; i++) begin
      #3; chk("R7 gclk follows", gclk, fan_clk);
    end
    @(negedge clk);

    // R2
    mem_off_req = 1'b1; cyc(1);
    chk("R2 level memoff", level, 1);
    chk("R2 bank on", bank_off, 1);
    chk("R2 no req", stby_req, 0);
    mem_off_req = 1'b0; cyc(1);
    chk("R2 back to full", level, 0);
    chk("R2 bank off", bank_off, 0);

    // R3 from full: passes memoff
    sleep_req = 1'b1; cyc(1);
    chk("R3 memoff step", level, 1);
    chk("R3 no req yet", stby_req, 0);
    cyc(1);
    chk("R3 prepare", level, 2);
    chk("R3 req high", stby_req, 1);
    chk("R3 bank high", bank_off, 1);
    sleep_req = 1'b0;

    // R4: no acknowledge, stays in prepare
    cyc(10);
    chk("R4 held level", level, 2);
    chk("R4 held req", stby_req, 1);
    ack_en = 1'b1;
    for (int i = 0; i < 20 && level != 3'd3; i++) begin
      chk("R4 req while waiting", stby_req, 1);
      cyc(1);
    end
    chk("R4 standby reached", level, 3);

    // R5: standby steady, requests ignored
    mem_off_req = 1'b1; sleep_req = 1'b1; cyc(5);
    chk("R5 level steady", level, 3);
    chk("R5 req steady", stby_req, 1);
    chk("R5 bank steady", bank_off, 1);
    chk("R5 clr low", flag_clr, 0);
    mem_off_req = 1'b0; sleep_req = 1'b0;
    // R7: blocked while stdby high
    for (int i = 0; i < 5; i++) begin
      #3; chk("R7 gclk blocked", gclk, 0);
    end
    @(negedge clk);

    // R5 wake latency, R6, R8
    exp_q.push_back("R6 first");
    wake = 1'b1; cyc(2);
    chk("R5 still standby after 2 edges", level, 3);
    cyc(1);
    chk("R5 wakeup level", level, 4);
    chk("R5 req dropped", stby_req, 0);
    wake = 1'b0;
    cyc(1);
    chk("R6 no clear before stdby low", flag_clr, 0);
    cyc(1);
    chk("R6 clear level", level, 5);
    chk("R6 clear pulse", flag_clr, 1);
    cyc(1);
    chk("R8 full again", level, 0);
    chk("R8 bank low", bank_off, 0);
    chk("R6 sflag cleared", sflag_m, 0);

    // R3 from memoff, R8 pending memoff after clear
    mem_off_req = 1'b1; cyc(1);
    chk("R2 memoff", level, 1);
    sleep_req = 1'b1; cyc(1);
    chk("R3 prepare from memoff", level, 2);
    sleep_req = 1'b0;
    for (int i = 0; i < 20 && level != 3'd3; i++) cyc(1);
    chk("R4 standby again", level, 3);
    exp_q.push_back("R6 second");
    wake = 1'b1;
    for (int i = 0; i < 20 && level != 3'd5; i++) cyc(1);
    chk("R6 second clear", flag_clr, 1);
    cyc(1);
    chk("R8 full after clear", level, 0);
    cyc(1);
    chk("R8 pending memoff honoured", level, 1);
    wake = 1'b0; mem_off_req = 1'b0;
    cyc(3);
    chk("R6 all pulses seen", exp_q.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule